// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Unit

This block sits next to a small host core. Each cycle the core may present one instruction word with its address, its condition flags and its status word. The block decides whether the word is a coprocessor-class instruction and tests its condition field against the host flags. It then works out which of up to sixteen attached coprocessor slots the word addresses. If that slot is present, the block offers the word to it, and holds the core with a stall while the slot reports busy.

When the addressed slot is absent, the block raises an undefined-instruction trap on the following clock edge. The trap output comes with the vector address to fetch from. It also carries the return address, the status word as it was before the trap, and the status word the core must install: undefined mode with interrupt requests disabled. Software can then emulate the missing hardware and return to the next instruction. A coprocessor instruction whose condition fails is retired as a no-op: nothing is offered and no trap is raised. The coprocessor datapaths and any memory transfers are outside this block.

Top module: `cop_dispatch`

## Requirements
- R1: `cls` reports the instruction class: 0 not coprocessor, 1 data operation, 2 load to coprocessor, 3 store from coprocessor, 4 move core to coprocessor, 5 move coprocessor to core. Bits [27:24] of 0xC or 0xD give load (bit 20 = 1) or store (bit 20 = 0). A value of 0xE gives a data operation when bit 4 = 0. Otherwise 0xE gives a move to the core (bit 20 = 1) or from the core (bit 20 = 0). Any other value is not a coprocessor instruction.
- R2: The condition in bits [31:28] is tested against the host flags only, with `flags` = {N,Z,C,V}. The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 always; 15 never.
- R3: A valid coprocessor instruction whose condition fails raises `skip` in the same cycle, with `cp_offer` zero, `stall` low and no trap on the next edge.
- R4: A valid coprocessor instruction whose condition passes drives `cp_offer` one-hot on the slot named by bits [11:8], and only if that slot's `cp_present` bit is set.
- R5: `stall` is high exactly while the offered slot has its `cp_busy` bit set.
- R6: `done` is high exactly when the offered slot is not busy, that is, when it accepts the instruction.
- R7: A valid coprocessor instruction whose condition passes but whose slot is absent makes `trap` high for one cycle after the next rising edge. In that cycle `trap_target` is 0x00000004.
- R8: On a trap, `save_pc` becomes the trapping instruction's address plus 4 and `save_psr` becomes the `psr_in` value seen with it. Both hold until the next trap, and both are zero after reset.
- R9: On a trap, `trap_psr` equals the saved status word with bits [4:0] set to 0x1B and bit 7 set, and every other bit kept.
- R10: A word that is not coprocessor-class, or a cycle with `ins_valid` low, leaves `cp_offer`, `stall`, `done`, `skip` and the trap all inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction word present this cycle |
| ins_word | input | 32 | Instruction word |
| ins_pc | input | 32 | Address of the instruction |
| flags | input | 4 | Host flags {N,Z,C,V} |
| psr_in | input | 32 | Current host status word |
| cp_present | input | 16 | Slot fitted, one bit per coprocessor number |
| cp_busy | input | 16 | Slot busy, one bit per coprocessor number |
| cls | output | 3 | Decoded instruction class |
| cp_offer | output | 16 | One-hot offer to the addressed slot |
| stall | output | 1 | Hold the core, offered slot busy |
| done | output | 1 | Offered slot accepts the instruction |
| skip | output | 1 | Condition failed, retire as no-op |
| trap | output | 1 | Undefined-instruction trap pulse |
| trap_target | output | 32 | Fetch address for the trap |
| save_pc | output | 32 | Return address saved by the last trap |
| save_psr | output | 32 | Status word saved by the last trap |
| trap_psr | output | 32 | Status word the core installs on the trap |

## Verification
On every cycle the assertions check three things. The offer vector is never more than one-hot. A stall or a skip never comes with a wrong offer state. Any unclaimed instruction whose condition passes is followed by a trap that carries undefined mode, the IRQ-disable bit and the address-plus-4 return value. Only the bench's scenarios show that the class decode and all sixteen condition codes give the right answers for given words and flags. The same goes for the saved values holding across cycles without a trap, and for non-coprocessor words leaving every output idle.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
   typedef enum logic [2:0] {
      CLS_NONE  = 3'd0,
      CLS_DATA  = 3'd1,
      CLS_LOAD  = 3'd2,
      CLS_STORE = 3'd3,
      CLS_TOCP  = 3'd4,
      CLS_FROMCP = 3'd5
   } cop_cls_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;
endpackage

// File: rtl/cpd_cond_eval.sv
module cpd_cond_eval (
   input  logic [3:0] cond,
   input  logic [3:0] flags,
   output logic       pass
);
   import cpd_pkg::*;
   logic n, z, c, v;
   assign n = flags[FLAG_N];
   assign z = flags[FLAG_Z];
   assign c = flags[FLAG_C];
   assign v = flags[FLAG_V];

   always_comb begin
      unique case (cond)
         4'd0:  pass = z;
         4'd1:  pass = !z;
         4'd2:  pass = c;
         4'd3:  pass = !c;
         4'd4:  pass = n;
         4'd5:  pass = !n;
         4'd6:  pass = v;
         4'd7:  pass = !v;
         4'd8:  pass = c && !z;
         4'd9:  pass = !c || z;
         4'd10: pass = (n == v);
         4'd11: pass = (n != v);
         4'd12: pass = !z && (n == v);
         4'd13: pass = z || (n != v);
         4'd14: pass = 1'b1;
         default: pass = 1'b0;
      endcase
   end
endmodule

// File: rtl/cpd_decode.sv
module cpd_decode
   import cpd_pkg::*;
(
   input  logic [3:0] grp,
   input  logic       b20,
   input  logic       b4,
   output cop_cls_e   cls,
   output logic       is_cop
);
   always_comb begin
      cls = CLS_NONE;
      unique case (grp)
         4'hC, 4'hD: cls = b20 ? CLS_LOAD : CLS_STORE;
         4'hE: begin
            if (!b4)     cls = CLS_DATA;
            else if (b20) cls = CLS_FROMCP;
            else         cls = CLS_TOCP;
         end
         default: cls = CLS_NONE;
      endcase
   end
   assign is_cop = (cls != CLS_NONE);
endmodule

// File: rtl/cpd_trap_ctrl.sv
module cpd_trap_ctrl #(
   parameter int          DATA_W      = 32,
   parameter logic [31:0] VECTOR      = 32'h0000_0004,
   parameter logic [4:0]  UND_MODE    = 5'h1B,
   parameter int          IRQ_BIT     = 7,
   parameter int          INSN_BYTES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_req,
   input  logic [DATA_W-1:0] pc,
   input  logic [DATA_W-1:0] psr,
   output logic              trap,
   output logic [DATA_W-1:0] trap_target,
   output logic [DATA_W-1:0] save_pc,
   output logic [DATA_W-1:0] save_psr,
   output logic [DATA_W-1:0] trap_psr
);
   localparam logic [DATA_W-1:0] STEP = DATA_W'(INSN_BYTES);

   generate
      if (IRQ_BIT < 5 || IRQ_BIT >= DATA_W) begin : g_bad_irq
         $error("IRQ_BIT must lie above the mode field and inside the word");
      end
   endgenerate

   logic [DATA_W-1:0] psr_next;
   always_comb begin
      psr_next          = psr;
      psr_next[4:0]     = UND_MODE;
      psr_next[IRQ_BIT] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap     <= 1'b0;
         save_pc  <= '0;
         save_psr <= '0;
         trap_psr <= '0;
      end else begin
         trap <= trap_req;
         if (trap_req) begin
            save_pc  <= pc + STEP;
            save_psr <= psr;
            trap_psr <= psr_next;
         end
      end
   end

   assign trap_target = DATA_W'(VECTOR);

   p_trap_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> trap);
   p_trap_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> save_pc == $past(pc) + STEP);
   p_trap_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> (trap_psr[4:0] == UND_MODE) && trap_psr[IRQ_BIT]
               && (trap_psr[DATA_W-1:IRQ_BIT+1] == save_psr[DATA_W-1:IRQ_BIT+1]));
endmodule

// File: rtl/cop_dispatch.sv
module cop_dispatch #(
   parameter int NUM_SLOTS = 16,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ins_valid,
   input  logic [31:0]          ins_word,
   input  logic [DATA_W-1:0]    ins_pc,
   input  logic [3:0]           flags,
   input  logic [DATA_W-1:0]    psr_in,
   input  logic [NUM_SLOTS-1:0] cp_present,
   input  logic [NUM_SLOTS-1:0] cp_busy,
   output logic [2:0]           cls,
   output logic [NUM_SLOTS-1:0] cp_offer,
   output logic                 stall,
   output logic                 done,
   output logic                 skip,
   output logic                 trap,
   output logic [DATA_W-1:0]    trap_target,
   output logic [DATA_W-1:0]    save_pc,
   output logic [DATA_W-1:0]    save_psr,
   output logic [DATA_W-1:0]    trap_psr
);
   import cpd_pkg::*;
   localparam int NUM_W = 4;

   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > (1 << NUM_W)) begin : g_bad_slots
         $error("NUM_SLOTS must be between 1 and 16");
      end
      if (DATA_W < 32) begin : g_bad_width
         $error("DATA_W must be at least 32");
      end
   endgenerate

   cop_cls_e   cls_d;
   logic       is_cop, pass;
   logic [NUM_W-1:0] num;
   logic [NUM_SLOTS-1:0] sel;
   logic       live, hit, trap_req;
   logic       unused_bits;

   assign num = ins_word[11:8];
   assign unused_bits = ^{ins_word[23:21], ins_word[19:12], ins_word[7:5], ins_word[3:0]};

   cpd_decode u_dec (
      .grp   (ins_word[27:24]),
      .b20   (ins_word[20]),
      .b4    (ins_word[4]),
      .cls   (cls_d),
      .is_cop(is_cop)
   );

   cpd_cond_eval u_cond (
      .cond (ins_word[31:28]),
      .flags(flags),
      .pass (pass)
   );

   generate
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
         assign sel[i] = (num == NUM_W'(i));
      end
   endgenerate

   assign live     = ins_valid && is_cop && pass;
   assign hit      = |(sel & cp_present);
   assign cp_offer = live ? (sel & cp_present) : '0;
   assign stall    = |(cp_offer & cp_busy);
   assign done     = |(cp_offer & ~cp_busy);
   assign skip     = ins_valid && is_cop && !pass;
   assign trap_req = live && !hit;
   assign cls      = cls_d;

   cpd_trap_ctrl #(.DATA_W(DATA_W)) u_trap (
      .clk        (clk),
      .rst_n      (rst_n),
      .trap_req   (trap_req),
      .pc         (ins_pc),
      .psr        (psr_in),
      .trap       (trap),
      .trap_target(trap_target),
      .save_pc    (save_pc),
      .save_psr   (save_psr),
      .trap_psr   (trap_psr)
   );

   p_offer_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cp_offer));
   p_stall_offered_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (|cp_offer) && !done);
   p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      skip |-> (cp_offer == '0) && !stall ##1 !trap);
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_valid |-> (cp_offer == '0) && !skip ##1 !trap);
endmodule

// File: tb/cop_dispatch_test.sv
module cop_dispatch_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ins_valid;
   logic [31:0] ins_word, ins_pc, psr_in;
   logic [3:0]  flags;
   logic [15:0] cp_present, cp_busy;
   logic [2:0]  cls;
   logic [15:0] cp_offer;
   logic        stall, done, skip, trap;
   logic [31:0] trap_target, save_pc, save_psr, trap_psr;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   cop_dispatch uut (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
      .ins_pc(ins_pc), .flags(flags), .psr_in(psr_in), .cp_present(cp_present),
      .cp_busy(cp_busy), .cls(cls), .cp_offer(cp_offer), .stall(stall),
      .done(done), .skip(skip), .trap(trap), .trap_target(trap_target),
      .save_pc(save_pc), .save_psr(save_psr), .trap_psr(trap_psr)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] f_cls(input logic [31:0] w);
      case (w[27:24])
         4'hC, 4'hD: return w[20] ? 3'd2 : 3'd3;
         4'hE: return !w[4] ? 3'd1 : (w[20] ? 3'd5 : 3'd4);
         default: return 3'd0;
      endcase
   endfunction

   function automatic bit f_cond(input logic [3:0] c, input logic [3:0] f);
      bit n, z, cy, v;
      n = f[3]; z = f[2]; cy = f[1]; v = f[0];
      case (c)
         0: return z;          1: return !z;
         2: return cy;         3: return !cy;
         4: return n;          5: return !n;
         6: return v;          7: return !v;
         8: return cy && !z;   9: return !cy || z;
         10: return n == v;    11: return n != v;
         12: return !z && (n == v);
         13: return z || (n != v);
         14: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   logic [31:0] e_spc = 0, e_spsr = 0, e_tpsr = 0;

   // Drive one instruction at the falling edge, check combinational outputs,
   // then check the registered trap state after the next rising edge.
   task automatic step(input bit vld, input logic [31:0] w, input logic [31:0] pc,
                       input logic [3:0] f, input logic [31:0] psr,
                       input logic [15:0] pres, input logic [15:0] busy);
      logic [2:0]  ec;
      bit          cop, ok, live, hit, etrap;
      logic [15:0] eoff;
      @(negedge clk);
      ins_valid = vld; ins_word = w; ins_pc = pc; flags = f; psr_in = psr;
      cp_present = pres; cp_busy = busy;
      ec = f_cls(w);
      cop = (ec != 3'd0);
      ok = f_cond(w[31:28], f);
      live = vld && cop && ok;
      hit = pres[w[11:8]];
      eoff = (live && hit) ? (16'h1 << w[11:8]) : 16'h0;
      etrap = live && !hit;
      #2;
      chk("R1", "cls", 32'(cls), 32'(ec));
      chk(vld && cop ? "R4" : "R10", "offer", 32'(cp_offer), 32'(eoff));
      chk("R5", "stall", 32'(stall), 32'((eoff != 0) && busy[w[11:8]]));
      chk("R6", "done", 32'(done), 32'((eoff != 0) && !busy[w[11:8]]));
      chk(ok ? "R3" : "R2", "skip", 32'(skip), 32'(vld && cop && !ok));
      if (etrap) begin
         e_spc  = pc + 4;
         e_spsr = psr;
         e_tpsr = psr;
         e_tpsr[4:0] = 5'h1B;
         e_tpsr[7] = 1'b1;
      end
      @(posedge clk);
      #2;
      chk(vld && cop && !ok ? "R3" : "R7", "trap", 32'(trap), 32'(etrap));
      if (etrap) chk("R7", "trap_target", trap_target, 32'h4);
      chk("R8", "save_pc", save_pc, e_spc);
      chk("R8", "save_psr", save_psr, e_spsr);
      chk("R9", "trap_psr", trap_psr, e_tpsr);
   endtask

   initial begin
      #3_000_000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED_C0DE);
      rst_n = 0; ins_valid = 0; ins_word = 0; ins_pc = 0; flags = 0;
      psr_in = 0; cp_present = 0; cp_busy = 0;
      repeat (3) @(posedge clk);
      #2;
      chk("R8", "reset save_pc", save_pc, 0);
      chk("R8", "reset save_psr", save_psr, 0);
      chk("R7", "reset trap", 32'(trap), 0);
      @(negedge clk); rst_n = 1;

      // R4/R6: data op to present idle slot 15, always condition
      step(1, 32'hEE01_0F02, 32'h100, 4'h0, 32'h10, 16'h8000, 16'h0);
      // R5: same slot busy
      step(1, 32'hEE01_0F02, 32'h100, 4'h0, 32'h10, 16'h8000, 16'h8000);
      // R7/R8/R9: absent slot 1, psr with user mode
      step(1, 32'hEE01_0110, 32'h0000_8F78, 4'h0, 32'hF000_0010, 16'h8000, 16'h0);
      // R8: values hold on a quiet cycle
      step(0, 32'hEE01_0110, 32'h0, 4'h0, 32'h0, 16'h0, 16'h0);
      // R3: EQ fails with Z clear, slot absent -> no trap
      step(1, 32'h0E10_0310, 32'h200, 4'h0, 32'h13, 16'h0, 16'h0);
      // R2: EQ passes with Z set, load to slot 3
      step(1, 32'h0D10_0300, 32'h204, 4'h4, 32'h13, 16'h0008, 16'h0);
      // R2: never code
      step(1, 32'hFE00_0010, 32'h208, 4'hF, 32'h13, 16'hFFFF, 16'h0);
      // R10: non-coprocessor word
      step(1, 32'hE1A0_F00E, 32'h20C, 4'h0, 32'h13, 16'hFFFF, 16'h0);
      // R1: store class, move-from-core class
      step(1, 32'hEC00_0500, 32'h210, 4'h0, 32'h1F, 16'h0020, 16'h0);
      step(1, 32'hEE00_0F10, 32'h214, 4'h0, 32'h1F, 16'h0000, 16'h0);

      for (int k = 0; k < 400; k++) begin
         logic [31:0] w;
         logic [3:0]  g;
         w = $urandom;
         case ($urandom % 4)
            0: g = 4'hC; 1: g = 4'hD; 2: g = 4'hE; default: g = 4'($urandom);
         endcase
         w[27:24] = g;
         step(($urandom % 8) != 0, w, $urandom & 32'hFFFF_FFFC, 4'($urandom),
              $urandom, 16'($urandom), 16'($urandom));
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule